// File: doc/BRIEF.md
# SPI Flash Identification Reader

This block is a host-side SPI master that fetches identification bytes from a serial flash. A one-cycle start pulse, qualified by a command select and a width select, launches one of three fixed transactions: the standard three-byte ID read, the manufacturer/device ID read with a zero address at one, two or four bits per clock, or the wake-from-power-down read that also returns a single device ID byte. The block drives the serial clock, the chip select and the outgoing IO lanes with their output enables. It captures the reply, packs it into a right-justified word and signals completion with a one-cycle pulse.

A single shift engine carries the opcode, the address and the reply. The number of lanes it uses is set per phase. The opcode always goes out on lane 0, one bit per clock. The address and the reply use the lane count of the selected variant. The serial clock runs in mode 0, and its half period is a parameter. Chip select stays high for a programmable number of whole SCLK periods after every transaction, and start pulses in that window are ignored.

Top module: `spi_id_reader`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy is 0, done is 0, io_oe is 0 and id_data is 0.
- R2: sclk is low whenever cs_n is high. While cs_n is low, each sclk half period lasts HALF_DIV clock cycles, and the first half period after cs_n falls is a low one.
- R3: The opcode is sent MSB first on io_out[0] with io_oe = 0001, one bit per sclk. cmd_sel 0 selects 9Fh. cmd_sel 1 selects 90h, 92h or 94h for width_sel 0, 1, or 2/3. cmd_sel 2 or 3 selects ABh.
- R4: For opcodes 90h/92h/94h a 24-bit zero address follows at 1/2/4 bits per sclk. io_oe is 0001/0011/1111 during the address, and the most significant bit of each group is on the highest lane used.
- R5: After ABh, 24 zero bits are sent on io_out[0] at one bit per sclk, then one reply byte is read on io_in[0]. width_sel has no effect on this command.
- R6: Reply bits are sampled on the rising sclk edge, MSB first, with io_in[w-1] carrying the most significant bit of each w-bit group. id_data is {b0,b1,b2} for 9Fh, {00h,b0,b1} for the 90h family and {0000h,b0} for ABh, where b0 is the first byte received.
- R7: io_oe is 0000 during the reply phase and whenever cs_n is high.
- R8: done is a one-cycle pulse in the first cycle in which cs_n is high again. id_data keeps its value from that cycle until the next accepted start.
- R9: After each transaction, busy stays 1 and cs_n stays 1 for 2*HALF_DIV*GAP_SCLK cycles. A start pulse while busy is 1 is ignored.
- R10: id_err pulses with done when b0 differs from EFh for 9Fh or the 90h family. It never pulses for ABh.
- R11: cs_n stays low for exactly N sclk periods: N = 32 for 9Fh, 8+24/w+16/w for the 90h family, and 40 for ABh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken only when busy is 0 |
| cmd_sel | input | 2 | Transaction select (0 standard ID, 1 manufacturer/device ID, 2/3 wake) |
| width_sel | input | 2 | Lane count for the manufacturer/device ID read (0 single, 1 dual, 2/3 quad) |
| sclk | output | 1 | Serial clock, mode 0 |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Outgoing data lanes |
| io_oe | output | 4 | Per-lane output enable |
| io_in | input | 4 | Incoming data lanes |
| busy | output | 1 | Transaction or guard interval in progress |
| done | output | 1 | One-cycle completion pulse |
| id_data | output | 24 | Right-justified reply bytes |
| id_err | output | 1 | Manufacturer byte mismatch, valid with done |

## Verification
The bench builds the block with HALF_DIV = 3, GAP_SCLK = 2 and ADDR_W = 24. The odd divider makes the low and high halves of sclk each three cycles long, so an off-by-one in the half-period counter or in the phase clock counts shifts every expected edge. The short guard lets back-to-back transactions and start pulses during the guard be checked within a few hundred cycles. A behavioural flash model decodes the opcode it receives, checks the address lanes and enables, and answers on the falling sclk edge. The timeline reference is compared with sclk, cs_n, busy and done on every cycle.

// File: rtl/sid_pkg.sv
package sid_pkg;

    typedef enum logic [1:0] {
        CMD_STD  = 2'd0,
        CMD_MFR  = 2'd1,
        CMD_WAKE = 2'd2
    } cmd_e;

    typedef enum logic [1:0] {
        LANE_X1 = 2'd0,
        LANE_X2 = 2'd1,
        LANE_X4 = 2'd2
    } lane_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_OPC   = 3'd1,
        PH_ADDR  = 3'd2,
        PH_RX    = 3'd3,
        PH_GUARD = 3'd4
    } phase_e;

    typedef struct packed {
        cmd_e  cmd;
        lane_e lane;
    } req_t;

    localparam logic [7:0] OPC_STD    = 8'h9F;
    localparam logic [7:0] OPC_MFR_X1 = 8'h90;
    localparam logic [7:0] OPC_MFR_X2 = 8'h92;
    localparam logic [7:0] OPC_MFR_X4 = 8'h94;
    localparam logic [7:0] OPC_WAKE   = 8'hAB;
    localparam logic [7:0] MFR_CODE   = 8'hEF;
    localparam int         ID_W       = 24;

    function automatic cmd_e decode_cmd(input logic [1:0] sel);
        if (sel[1])      return CMD_WAKE;
        else if (sel[0]) return CMD_MFR;
        else             return CMD_STD;
    endfunction

    function automatic lane_e decode_lane(input logic [1:0] sel);
        if (sel[1])      return LANE_X4;
        else if (sel[0]) return LANE_X2;
        else             return LANE_X1;
    endfunction

    // Lane count used by the address and reply phases of a request
    function automatic lane_e data_lane(input req_t r);
        return (r.cmd == CMD_MFR) ? r.lane : LANE_X1;
    endfunction

    function automatic int lane_bits(input lane_e l);
        case (l)
            LANE_X2: return 2;
            LANE_X4: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(input lane_e l);
        case (l)
            LANE_X2: return 4'b0011;
            LANE_X4: return 4'b1111;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic int resp_bytes(input cmd_e c);
        case (c)
            CMD_STD: return 3;
            CMD_MFR: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] opcode_of(input req_t r);
        case (r.cmd)
            CMD_STD: return OPC_STD;
            CMD_MFR: begin
                case (r.lane)
                    LANE_X2: return OPC_MFR_X2;
                    LANE_X4: return OPC_MFR_X4;
                    default: return OPC_MFR_X1;
                endcase
            end
            default: return OPC_WAKE;
        endcase
    endfunction

endpackage

// File: rtl/sid_sclk_gen.sv
module sid_sclk_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic rise,
    output logic fall
);
    localparam int              HC_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_DIV - 1);

    logic [HC_W-1:0] hc;
    logic            wrap;

    assign wrap = run && (hc == HC_LAST);
    assign rise = wrap && !sclk;
    assign fall = wrap && sclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hc   <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            hc   <= '0;
            sclk <= ~sclk;
        end else begin
            hc   <= hc + 1'b1;
        end
    end
endmodule

// File: rtl/sid_shift_unit.sv
module sid_shift_unit
    import sid_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [7:0]       opcode,
    input  logic             tx_en,
    input  logic             tx_step,
    input  logic             rx_step,
    input  lane_e            lane,
    input  logic [3:0]       io_in,
    output logic [3:0]       io_out,
    output logic [ID_W-1:0]  rx_word
);
    localparam int TX_W = 8 + ADDR_W;

    logic [TX_W-1:0] tx_sr;

    // Outgoing lanes: the top bits of the shift register, highest lane most significant
    always_comb begin
        io_out = 4'b0000;
        if (tx_en) begin
            case (lane)
                LANE_X2: io_out = {2'b00, tx_sr[TX_W-1 -: 2]};
                LANE_X4: io_out = tx_sr[TX_W-1 -: 4];
                default: io_out = {3'b000, tx_sr[TX_W-1]};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= {opcode, {ADDR_W{1'b0}}};
        end else if (tx_step) begin
            case (lane)
                LANE_X2: tx_sr <= tx_sr << 2;
                LANE_X4: tx_sr <= tx_sr << 4;
                default: tx_sr <= tx_sr << 1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            rx_word <= '0;
        end else if (rx_step) begin
            case (lane)
                LANE_X2: rx_word <= {rx_word[ID_W-3:0], io_in[1:0]};
                LANE_X4: rx_word <= {rx_word[ID_W-5:0], io_in[3:0]};
                default: rx_word <= {rx_word[ID_W-2:0], io_in[0]};
            endcase
        end
    end
endmodule

// File: rtl/sid_phase_ctl.sv
module sid_phase_ctl
    import sid_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int HALF_DIV = 4,
    parameter int GAP_SCLK = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  req_t   req_in,
    input  logic   fall,
    output phase_e phase,
    output req_t   req,
    output logic   accept,
    output logic   done
);
    localparam int GUARD_CYC = 2 * HALF_DIV * GAP_SCLK;
    localparam int GW        = $clog2(GUARD_CYC + 1);
    localparam int CNT_MAX   = (ADDR_W > ID_W) ? ADDR_W : ID_W;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [GW-1:0]    gcnt;
    logic [CNT_W-1:0] addr_last;
    logic [CNT_W-1:0] rx_last;

    assign accept = (phase == PH_IDLE) && start;

    // Last clock index of each phase, counted in whole sclk periods
    always_comb begin
        addr_last = CNT_W'(ADDR_W / lane_bits(data_lane(req)) - 1);
        rx_last   = CNT_W'(resp_bytes(req.cmd) * 8 / lane_bits(data_lane(req)) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            req.cmd  <= CMD_STD;
            req.lane <= LANE_X1;
            cnt      <= '0;
            gcnt     <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        req   <= req_in;
                        phase <= PH_OPC;
                        cnt   <= CNT_W'(7);
                    end
                end
                PH_OPC: begin
                    if (fall) begin
                        if (cnt == '0) begin
                            if (req.cmd == CMD_STD) begin
                                phase <= PH_RX;
                                cnt   <= rx_last;
                            end else begin
                                phase <= PH_ADDR;
                                cnt   <= addr_last;
                            end
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                PH_ADDR: begin
                    if (fall) begin
                        if (cnt == '0) begin
                            phase <= PH_RX;
                            cnt   <= rx_last;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                PH_RX: begin
                    if (fall) begin
                        if (cnt == '0) begin
                            phase <= PH_GUARD;
                            gcnt  <= '0;
                            done  <= 1'b1;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                PH_GUARD: begin
                    if (gcnt == GW'(GUARD_CYC - 1)) begin
                        phase <= PH_IDLE;
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_id_reader.sv
module spi_id_reader
    import sid_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int GAP_SCLK = 2,
    parameter int ADDR_W   = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  cmd_sel,
    input  logic [1:0]  width_sel,
    output logic        sclk,
    output logic        cs_n,
    output logic [3:0]  io_out,
    output logic [3:0]  io_oe,
    input  logic [3:0]  io_in,
    output logic        busy,
    output logic        done,
    output logic [23:0] id_data,
    output logic        id_err
);
    req_t      req_in;
    req_t      req;
    phase_e    phase;
    lane_e     cur_lane;
    logic      accept;
    logic      run;
    logic      rise;
    logic      fall;
    logic      tx_en;
    logic      rx_en;
    logic [7:0] first_byte;
    logic [ID_W-1:0] rx_word;

    always_comb begin
        req_in.cmd  = decode_cmd(cmd_sel);
        req_in.lane = decode_lane(width_sel);
    end

    assign run   = (phase == PH_OPC) || (phase == PH_ADDR) || (phase == PH_RX);
    assign tx_en = (phase == PH_OPC) || (phase == PH_ADDR);
    assign rx_en = (phase == PH_RX);

    always_comb begin
        if (phase == PH_OPC) cur_lane = LANE_X1;
        else                 cur_lane = data_lane(req);
    end

    sid_phase_ctl #(
        .ADDR_W   (ADDR_W),
        .HALF_DIV (HALF_DIV),
        .GAP_SCLK (GAP_SCLK)
    ) u_ctl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .req_in (req_in),
        .fall   (fall),
        .phase  (phase),
        .req    (req),
        .accept (accept),
        .done   (done)
    );

    sid_sclk_gen #(
        .HALF_DIV (HALF_DIV)
    ) u_clk (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .sclk (sclk),
        .rise (rise),
        .fall (fall)
    );

    sid_shift_unit #(
        .ADDR_W (ADDR_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .opcode  (opcode_of(req_in)),
        .tx_en   (tx_en),
        .tx_step (fall && tx_en),
        .rx_step (rise && rx_en),
        .lane    (cur_lane),
        .io_in   (io_in),
        .io_out  (io_out),
        .rx_word (rx_word)
    );

    assign cs_n    = !run;
    assign busy    = (phase != PH_IDLE);
    assign io_oe   = tx_en ? lane_mask(cur_lane) : 4'b0000;
    assign id_data = rx_word;

    assign first_byte = (req.cmd == CMD_STD) ? rx_word[23:16] : rx_word[15:8];
    assign id_err     = done && (req.cmd != CMD_WAKE) && (first_byte != MFR_CODE);
endmodule

// File: rtl/sid_checker.sv
module sid_checker #(
    parameter int HALF_DIV = 4,
    parameter int GAP_SCLK = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        sclk,
    input logic        cs_n,
    input logic [3:0]  io_oe,
    input logic        busy,
    input logic        done,
    input logic [23:0] id_data,
    input logic        id_err
);
    localparam int GUARD_CYC = 2 * HALF_DIV * GAP_SCLK;
    localparam int GW        = $clog2(GUARD_CYC + 1);

    logic [GW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)                          hi_cnt <= GW'(GUARD_CYC);
        else if (!cs_n)                   hi_cnt <= '0;
        else if (hi_cnt != GW'(GUARD_CYC)) hi_cnt <= hi_cnt + 1'b1;
    end

    a_r2_sclk_parked: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    a_r7_oe_quiet: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (io_oe == 4'b0000));

    a_r4_oe_shape: assert property (@(posedge clk) disable iff (rst)
        (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b0011) || (io_oe == 4'b1111));

    a_r8_done_once: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_at_release: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && !$past(cs_n) && busy));

    a_r8_data_held: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && !$past(start && !busy)) |-> $stable(id_data));

    a_r9_guard_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (hi_cnt == GW'(GUARD_CYC)));

    a_r10_err_with_done: assert property (@(posedge clk) disable iff (rst)
        id_err |-> done);
endmodule

bind spi_id_reader sid_checker #(
    .HALF_DIV (HALF_DIV),
    .GAP_SCLK (GAP_SCLK)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .io_oe   (io_oe),
    .busy    (busy),
    .done    (done),
    .id_data (id_data),
    .id_err  (id_err)
);

// File: tb/spi_id_reader_tb.sv
`timescale 1ns/1ps
module spi_id_reader_tb;
    localparam int HALF = 3;
    localparam int GAP  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  cmd_sel = 2'd0;
    logic [1:0]  width_sel = 2'd0;
    logic        sclk;
    logic        cs_n;
    logic [3:0]  io_out;
    logic [3:0]  io_oe;
    logic [3:0]  io_in;
    logic        busy;
    logic        done;
    logic [23:0] id_data;
    logic        id_err;

    int nchk = 0;
    int nerr = 0;

    // flash model state
    logic [7:0]  m_mfr = 8'hEF;
    logic [7:0]  m_type = 8'h40;
    logic [7:0]  m_cap = 8'h14;
    logic [7:0]  m_dev = 8'h13;
    logic [7:0]  dev_opc;
    logic [23:0] dev_resp;
    logic [3:0]  dev_io = 4'h0;
    int          dev_rcv;
    int          dev_w;
    int          dev_addr_left;
    int          dev_bad = 0;
    bit          dev_talk;

    always #2 clk = ~clk;

    assign io_in = dev_io;

    spi_id_reader #(.HALF_DIV(HALF), .GAP_SCLK(GAP), .ADDR_W(24)) u_dut (
        .clk(clk), .rst(rst), .start(start), .cmd_sel(cmd_sel), .width_sel(width_sel),
        .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in),
        .busy(busy), .done(done), .id_data(id_data), .id_err(id_err)
    );

    always @(negedge cs_n) begin
        dev_rcv       = 0;
        dev_opc       = 8'h00;
        dev_talk      = 1'b0;
        dev_io        = 4'h0;
        dev_addr_left = 0;
        dev_w         = 1;
        dev_resp      = 24'h0;
    end

    always @(posedge sclk) begin
        if (cs_n === 1'b0) begin
            if (dev_rcv < 8) begin
                if (io_oe !== 4'b0001) dev_bad++;
                dev_opc = {dev_opc[6:0], io_out[0]};
                dev_rcv++;
                if (dev_rcv == 8) begin
                    case (dev_opc)
                        8'h9F: begin dev_w = 1; dev_addr_left = 0;  dev_resp = {m_mfr, m_type, m_cap}; dev_talk = 1'b1; end
                        8'h90: begin dev_w = 1; dev_addr_left = 24; dev_resp = {m_mfr, m_dev, 8'h00}; end
                        8'h92: begin dev_w = 2; dev_addr_left = 12; dev_resp = {m_mfr, m_dev, 8'h00}; end
                        8'h94: begin dev_w = 4; dev_addr_left = 6;  dev_resp = {m_mfr, m_dev, 8'h00}; end
                        8'hAB: begin dev_w = 1; dev_addr_left = 24; dev_resp = {m_dev, 16'h0000}; end
                        default: dev_bad++;
                    endcase
                end
            end else if (dev_addr_left > 0) begin
                if (dev_w == 1 && io_oe !== 4'b0001) dev_bad++;
                if (dev_w == 2 && io_oe !== 4'b0011) dev_bad++;
                if (dev_w == 4 && io_oe !== 4'b1111) dev_bad++;
                if (io_out !== 4'b0000) dev_bad++;
                dev_addr_left--;
                if (dev_addr_left == 0) dev_talk = 1'b1;
            end else begin
                if (io_oe !== 4'b0000) dev_bad++;
            end
        end
    end

    always @(negedge sclk) begin
        if (cs_n === 1'b0 && dev_talk) begin
            case (dev_w)
                2: begin dev_io = {2'b00, dev_resp[23:22]}; dev_resp = dev_resp << 2; end
                4: begin dev_io = dev_resp[23:20];          dev_resp = dev_resp << 4; end
                default: begin dev_io = {3'b000, dev_resp[23]}; dev_resp = dev_resp << 1; end
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Timeline reference: k counts cycles from the edge that accepts start
    task automatic run_txn(input logic [1:0] cs, input logic [1:0] ws, input logic [7:0] exp_opc,
                           input int nclk, input logic [23:0] exp_id, input logic exp_err, input bit poke);
        int t_sel;
        int t_gap;
        t_sel = nclk * 2 * HALF;
        t_gap = 2 * HALF * GAP;
        dev_bad = 0;
        @(negedge clk);
        start = 1'b1; cmd_sel = cs; width_sel = ws;
        @(negedge clk);
        start = 1'b0; cmd_sel = ~cs; width_sel = ~ws;
        for (int k = 0; k <= t_sel + t_gap; k++) begin
            if (k > 0) @(negedge clk);
            chk("R11 cs_n", {31'd0, cs_n}, {31'd0, !(k < t_sel)});
            chk("R2 sclk", {31'd0, sclk}, {31'd0, (k < t_sel) && ((k % (2 * HALF)) >= HALF)});
            chk("R8 done", {31'd0, done}, {31'd0, k == t_sel});
            chk("R9 busy", {31'd0, busy}, {31'd0, k < t_sel + t_gap});
            if (k >= t_sel) chk("R7 oe released", {28'd0, io_oe}, 32'd0);
            if (k == t_sel) begin
                chk("R6 id_data", {8'd0, id_data}, {8'd0, exp_id});
                chk("R10 id_err", {31'd0, id_err}, {31'd0, exp_err});
            end
            if (k == t_sel + t_gap) chk("R8 id_data held", {8'd0, id_data}, {8'd0, exp_id});
            start = poke && (k == 5 || k == t_sel + 2);
        end
        chk("R3 opcode", {24'd0, dev_opc}, {24'd0, exp_opc});
        chk("R4 R5 R7 lanes and enables", dev_bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL R8 watchdog: actual=no finish expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", {31'd0, cs_n}, 32'd1);
        chk("R1 sclk", {31'd0, sclk}, 32'd0);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 io_oe", {28'd0, io_oe}, 32'd0);
        chk("R1 id_data", {8'd0, id_data}, 32'd0);

        // R3 R6 standard ID
        run_txn(2'd0, 2'd0, 8'h9F, 32, {8'hEF, 8'h40, 8'h14}, 1'b0, 1'b0);
        // R4 single, dual, quad manufacturer/device ID
        m_dev = 8'h13;
        run_txn(2'd1, 2'd0, 8'h90, 48, {8'h00, 8'hEF, 8'h13}, 1'b0, 1'b0);
        m_dev = 8'h5A;
        run_txn(2'd1, 2'd1, 8'h92, 28, {8'h00, 8'hEF, 8'h5A}, 1'b0, 1'b0);
        m_dev = 8'hA5;
        run_txn(2'd1, 2'd2, 8'h94, 18, {8'h00, 8'hEF, 8'hA5}, 1'b0, 1'b0);
        m_dev = 8'h3C;
        run_txn(2'd1, 2'd3, 8'h94, 18, {8'h00, 8'hEF, 8'h3C}, 1'b0, 1'b0);
        // R5 wake, width select has no effect
        m_dev = 8'h13;
        run_txn(2'd2, 2'd2, 8'hAB, 40, {16'h0000, 8'h13}, 1'b0, 1'b0);
        m_dev = 8'h96;
        run_txn(2'd3, 2'd1, 8'hAB, 40, {16'h0000, 8'h96}, 1'b0, 1'b0);
        // R10 manufacturer mismatch
        m_mfr = 8'hC2; m_type = 8'h20; m_cap = 8'h17; m_dev = 8'h71;
        run_txn(2'd0, 2'd0, 8'h9F, 32, {8'hC2, 8'h20, 8'h17}, 1'b1, 1'b0);
        run_txn(2'd1, 2'd2, 8'h94, 18, {8'h00, 8'hC2, 8'h71}, 1'b1, 1'b0);
        run_txn(2'd2, 2'd0, 8'hAB, 40, {16'h0000, 8'h71}, 1'b0, 1'b0);
        // R9 start pulses while busy are ignored
        m_mfr = 8'hEF; m_type = 8'h60; m_cap = 8'h15;
        run_txn(2'd0, 2'd0, 8'h9F, 32, {8'hEF, 8'h60, 8'h15}, 1'b0, 1'b1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R9 no restart after ignored start", {31'd0, cs_n}, 32'd1);
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule